// File: doc/BRIEF.md
# Self-Restoring Triplicated Storage Stage

This block holds one W-bit symbol in triplicate without a conventional majority voter. Each of the three redundant input copies passes through its own instance of the same combinational function (an add-constant stage here). The three results then go to three storage cells that act as unanimous-vote elements. Each cell updates only when its two inputs agree as whole symbols. Otherwise it keeps its contents. The cells are wired in a rotated feedback ring, so any cell that is upset is pulled back to the agreed value by its neighbours. Once the stage has settled, a brief glitch on one computed copy has no effect at all.

Operation has two phases. The load phase fills each cell from a neighbouring channel in rotated order. The correction phase then lets the ring settle for a parameterised number of cycles, after which `settled` rises. Outputs are meant to be used only while `settled` is high. A fresh symbol is taken by pulsing `restart`. Per-channel XOR masks on each computed copy and on each cell allow a testbench to inject faults. The stage carries one symbol at a time and has no streaming handshake. The restart pulse is its only flow control.

Top module: `rfb_triple_reg`

## Requirements
- R1: Each channel k computes its value as (in_k + INC) modulo 2^W, XOR the glitch mask fy_k. Defaults are W=8 and INC=0x35. In a fault-free run all three outputs end equal to (in + INC) mod 256.
- R2: In the correction phase, with no upset mask applied, a cell whose own channel value equals its paired cell's contents takes that value at the next edge.
- R3: In the correction phase, a cell whose two inputs differ in any bit (even one bit) keeps its contents at the next edge.
- R4: The load phase lasts one edge and loads cell A from channel B, cell B from channel C and cell C from channel A.
- R5: In the correction phase, cell A compares channel A with cell C, cell B compares channel B with cell A, and cell C compares channel C with cell B.
- R6: `settled` rises T edges (default 2) after the load edge and stays high. A `restart` sampled high enters the load phase and clears `settled` at the next edge.
- R7: A synchronous `rst` clears all three cells to zero, clears `settled` and selects the load phase for the following edge.
- R8: When all three cells agree in the correction phase, a nonzero glitch mask on any one channel leaves every output unchanged.
- R9: A nonzero upset mask fc_k XORs cell k at that edge. The affected output is wrong for exactly one cycle and is restored at the next edge, and the other two outputs are unchanged.
- R10: With one faulty input copy, the faulty channel's output settles to that channel's own computed value, and the other two outputs settle to the agreed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Starts a new load phase |
| in_a | input | W | Input copy, channel A |
| in_b | input | W | Input copy, channel B |
| in_c | input | W | Input copy, channel C |
| fy_a | input | W | Glitch XOR mask on computed value, channel A |
| fy_b | input | W | Glitch XOR mask on computed value, channel B |
| fy_c | input | W | Glitch XOR mask on computed value, channel C |
| fc_a | input | W | Upset XOR mask on cell A |
| fc_b | input | W | Upset XOR mask on cell B |
| fc_c | input | W | Upset XOR mask on cell C |
| out_a | output | W | Held symbol, cell A |
| out_b | output | W | Held symbol, cell B |
| out_c | output | W | Held symbol, cell C |
| settled | output | 1 | Correction window has elapsed |

## Verification
A restart is registered at the first edge. The load happens at the second edge, and `settled` appears T edges after that, which is the fourth edge with T=2. The bench counts these edges and checks the rotated load values after edge two, the correction result after edge three, and `settled` before and after edge four. Glitch and upset masks are applied for exactly one edge. The outputs are sampled on the falling edge right after that edge, and a restoration check follows one edge later. All inputs are driven and all outputs sampled on falling edges, so each check falls in a known cycle.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int NCH = 3;

  typedef enum logic [0:0] {
    PH_LOAD = 1'b0,
    PH_CORR = 1'b1
  } phase_t;

  // channel a cell loads from during the load phase
  function automatic int load_src(input int k);
    return (k + 1) % NCH;
  endfunction

  // cell a cell is paired with during correction
  function automatic int peer_of(input int k);
    return (k + 2) % NCH;
  endfunction
endpackage

// File: rtl/rfb_func.sv
module rfb_func #(
  parameter int W = 8,
  parameter logic [W-1:0] INC = W'(8'h35)
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] glitch,
  output logic [W-1:0] y
);
  logic [W-1:0] sum;

  always_comb begin
    sum = x + INC;
    y   = sum ^ glitch;
  end
endmodule

// File: rtl/rfb_cell.sv
module rfb_cell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] own,
  input  logic [W-1:0] peer,
  input  logic [W-1:0] upset,
  output logic [W-1:0] q
);
  logic agree;
  logic hit;

  always_comb begin
    agree = (own == peer);
    hit   = |upset;
  end

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (hit)   q <= q ^ upset;
    else if (load)  q <= load_val;
    else if (agree) q <= own;
  end

  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (q == '0));

  a_r4_rotated_load: assert property (@(posedge clk) disable iff (rst)
    (load && upset == '0) |=> (q == $past(load_val)));

  a_r2_agree_update: assert property (@(posedge clk) disable iff (rst)
    (!load && upset == '0 && own == peer) |=> (q == $past(own)));

  a_r3_disagree_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && upset == '0 && own != peer) |=> $stable(q));
endmodule

// File: rtl/rfb_phase_ctl.sv
module rfb_phase_ctl
  import rfb_pkg::*;
#(
  parameter int T = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic load,
  output logic settled
);
  localparam int CW = (T < 2) ? 1 : $clog2(T + 1);
  localparam logic [CW-1:0] TLIM = CW'(T);

  phase_t        phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= PH_LOAD;
      cnt   <= '0;
    end else if (phase == PH_LOAD) begin
      phase <= PH_CORR;
      cnt   <= '0;
    end else if (cnt != TLIM) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    load    = (phase == PH_LOAD);
    settled = (phase == PH_CORR) && (cnt == TLIM);
  end

  a_r7_reset_phase: assert property (@(posedge clk)
    rst |=> (load && !settled));

  a_r6_restart_drop: assert property (@(posedge clk) disable iff (rst)
    restart |=> (load && !settled));

  a_r6_settled_sticky: assert property (@(posedge clk) disable iff (rst)
    (settled && !restart) |=> settled);

  a_r4_single_load: assert property (@(posedge clk) disable iff (rst)
    (load && !restart) |=> !load);
endmodule

// File: rtl/rfb_triple_reg.sv
module rfb_triple_reg
  import rfb_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] INC = W'(8'h35),
  parameter int T = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  input  logic [W-1:0] fy_a,
  input  logic [W-1:0] fy_b,
  input  logic [W-1:0] fy_c,
  input  logic [W-1:0] fc_a,
  input  logic [W-1:0] fc_b,
  input  logic [W-1:0] fc_c,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b,
  output logic [W-1:0] out_c,
  output logic         settled
);
  logic [W-1:0] xin [NCH];
  logic [W-1:0] gm  [NCH];
  logic [W-1:0] um  [NCH];
  logic [W-1:0] yv  [NCH];
  logic [W-1:0] cv  [NCH];
  logic         load;

  always_comb begin
    xin[0] = in_a; xin[1] = in_b; xin[2] = in_c;
    gm[0]  = fy_a; gm[1]  = fy_b; gm[2]  = fy_c;
    um[0]  = fc_a; um[1]  = fc_b; um[2]  = fc_c;
  end

  rfb_phase_ctl #(.T(T)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .load    (load),
    .settled (settled)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    rfb_func #(.W(W), .INC(INC)) u_func (
      .x      (xin[g]),
      .glitch (gm[g]),
      .y      (yv[g])
    );

    rfb_cell #(.W(W)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (yv[load_src(g)]),
      .own      (yv[g]),
      .peer     (cv[peer_of(g)]),
      .upset    (um[g]),
      .q        (cv[g])
    );
  end

  always_comb begin
    out_a = cv[0];
    out_b = cv[1];
    out_c = cv[2];
  end

  // R8: an agreeing ring ignores every computed value
  a_r8_glitch_reject: assert property (@(posedge clk) disable iff (rst)
    (!load && cv[0] == cv[1] && cv[1] == cv[2] &&
     fc_a == '0 && fc_b == '0 && fc_c == '0)
    |=> (cv[0] == $past(cv[0]) && cv[1] == $past(cv[0]) && cv[2] == $past(cv[0])));

  // R9: one upset cell never breaks the two-of-three majority
  a_r9_upset_majority: assert property (@(posedge clk) disable iff (rst)
    (!load && !restart && cv[0] == cv[1] && cv[1] == cv[2] &&
     $countones({|fc_a, |fc_b, |fc_c}) == 1)
    |=> ($countones({cv[0] == $past(cv[0]), cv[1] == $past(cv[0]),
                     cv[2] == $past(cv[0])}) >= 2));
endmodule

// File: tb/tb_rfb_triple_reg.sv
module tb_rfb_triple_reg;
  localparam int W = 8;
  localparam logic [W-1:0] INC = 8'h35;
  localparam int T = 2;
  localparam int NV = 6;

  // {in_a, in_b, in_c, exp_a, exp_b, exp_c}
  localparam logic [47:0] VEC [NV] = '{
    48'h10_10_10_45_45_45,
    48'hF0_F0_F0_25_25_25,
    48'h00_20_20_35_55_55,
    48'h20_00_20_55_35_55,
    48'h20_20_00_55_55_35,
    48'h01_02_03_36_37_38
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restart = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic [W-1:0] fy_a = '0, fy_b = '0, fy_c = '0;
  logic [W-1:0] fc_a = '0, fc_b = '0, fc_c = '0;
  logic [W-1:0] out_a, out_b, out_c;
  logic settled;

  int checks = 0;
  int fails = 0;
  bit over = 1'b0;

  always #4 clk = ~clk;

  rfb_triple_reg #(.W(W), .INC(INC), .T(T)) dut (
    .clk(clk), .rst(rst), .restart(restart),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .fy_a(fy_a), .fy_b(fy_b), .fy_c(fy_c),
    .fc_a(fc_a), .fc_b(fc_b), .fc_c(fc_c),
    .out_a(out_a), .out_b(out_b), .out_c(out_c),
    .settled(settled)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check3(input string tag, input logic [W-1:0] ea, eb, ec);
    check({tag, " out_a"}, out_a, ea);
    check({tag, " out_b"}, out_b, eb);
    check({tag, " out_c"}, out_c, ec);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] fn(input logic [W-1:0] v);
    return v + INC;
  endfunction

  initial begin
    #(8 * 20000);
    if (!over) begin
      fails++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    in_a = 8'h01; in_b = 8'h02; in_c = 8'h03;
    step(); step();
    check3("R7 reset", 8'h00, 8'h00, 8'h00);
    check("R7 settled low", {7'd0, settled}, 8'h00);
    rst = 1'b0;
    step();
    // R4: rotated load after first edge out of reset
    check3("R4 rotated load", fn(8'h02), fn(8'h03), fn(8'h01));
    check("R6 not settled after load", {7'd0, settled}, 8'h00);
    step();
    // R5: pairing gives each cell its own channel value
    check3("R5 pairing", fn(8'h01), fn(8'h02), fn(8'h03));
    check("R6 not settled one edge in", {7'd0, settled}, 8'h00);
    step();
    check("R6 settled after T", {7'd0, settled}, 8'h01);

    // vector table: R1 fault-free, R10 single faulty copy
    for (int i = 0; i < NV; i++) begin
      {in_a, in_b, in_c} = VEC[i][47:24];
      restart = 1'b1;
      step();
      restart = 1'b0;
      check("R6 restart clears settled", {7'd0, settled}, 8'h00);
      step(); step();
      check("R6 still settling", {7'd0, settled}, 8'h00);
      step();
      check("R6 settled", {7'd0, settled}, 8'h01);
      check3((i < 2) ? "R1 vector" : "R10 vector", VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // settle on 0x10 for fault injection
    in_a = 8'h10; in_b = 8'h10; in_c = 8'h10;
    restart = 1'b1; step(); restart = 1'b0;
    step(); step(); step();
    check3("R1 base", 8'h45, 8'h45, 8'h45);

    // R8 glitches, R3 single-bit disagreement
    fy_a = 8'hFF; step(); fy_a = '0;
    check3("R8 glitch a", 8'h45, 8'h45, 8'h45);
    fy_b = 8'h01; step(); fy_b = '0;
    check3("R8 R3 one-bit glitch b", 8'h45, 8'h45, 8'h45);
    fy_c = 8'h80; step(); fy_c = '0;
    check3("R8 glitch c", 8'h45, 8'h45, 8'h45);

    // R9 cell upsets
    fc_a = 8'h0F; step(); fc_a = '0;
    check3("R9 upset a", 8'h4A, 8'h45, 8'h45);
    step();
    check3("R9 restore a", 8'h45, 8'h45, 8'h45);
    fc_b = 8'hF0; step(); fc_b = '0;
    check3("R9 upset b", 8'h45, 8'hB5, 8'h45);
    step();
    check3("R9 restore b", 8'h45, 8'h45, 8'h45);
    fc_c = 8'h01; step(); fc_c = '0;
    check3("R9 upset c", 8'h45, 8'h45, 8'h44);
    step();
    check3("R9 restore c", 8'h45, 8'h45, 8'h45);

    // R3: lasting one-bit change on channel A is held off
    in_a = 8'h11;
    step(); step(); step();
    check3("R3 hold", 8'h45, 8'h45, 8'h45);

    // R2: all copies move together, then upset A; it takes agreed value
    in_a = 8'h10;
    fc_a = 8'h33; step(); fc_a = '0;
    step();
    check3("R2 agree update", 8'h45, 8'h45, 8'h45);

    // R7: reset mid-run
    rst = 1'b1; step(); rst = 1'b0;
    check3("R7 mid reset", 8'h00, 8'h00, 8'h00);
    check("R7 mid reset settled", {7'd0, settled}, 8'h00);

    over = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule